// File: doc/BRIEF.md
# Four-Tap Mismatch Correlator

The block compares a stream of symbols against four reference symbols. For each accepted sample it reports how many of four positions disagree. Position 0 pairs the newest sample with reference 0. Position k pairs the sample accepted k samples earlier with reference k. The count is a 3-bit value from 0 to 4.

Samples travel along a history chain that moves only when a sample is accepted. Registers are placed so that no register-to-register path holds more than one symbol comparator and one adder. The first stage compares all four positions in parallel and adds two of the results. Each later stage adds one more result. The output therefore matches an unpipelined correlator delayed by exactly three advancing cycles.

Both streams use valid/ready. The output stage holds its value while `m_ready` is low. Every stage moves together on one advance condition: the output register is empty, or the consumer is taking its value. `s_ready` equals that condition, so back-pressure reaches the input in the same cycle and is never buffered. A reference write takes effect at the clock edge, so every sample accepted in a later cycle uses the new value. Writes are intended for idle cycles.

Top module: `corr_mismatch_top`

## Requirements
- R1: For each accepted sample x_t, the reported count equals (x_t != ref0) + (x_{t-1} != ref1) + (x_{t-2} != ref2) + (x_{t-3} != ref3). Here x_{t-k} is the sample accepted k acceptances earlier.
- R2: Each position adds 0 when its two symbols are equal and 1 otherwise. `m_count` is 3 bits wide and never exceeds 4 while `m_valid` is high.
- R3: The history chain moves only on accepted samples. Idle cycles and refused samples leave it unchanged. After reset every history entry is zero.
- R4: The result for a sample accepted in cycle c appears on `m_valid`/`m_count` after exactly three advancing cycles, including cycle c. This holds with no stall, and the sequence is the same as an unpipelined model delayed by three.
- R5: A cycle in which no sample is accepted places no result in the pipeline. It appears at the output three advancing cycles later as `m_valid` low.
- R6: `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_count` stays unchanged at the next edge.
- R7: When `ref_we` is high, `ref_data` replaces the reference chosen by `ref_sel` (0 to 3 = tap 0 to tap 3) at the clock edge. Samples accepted in later cycles use the new value. A sample accepted in the same cycle uses the old value.
- R8: Synchronous reset clears `m_valid`, all four references and the history chain. In the cycle after a reset edge, `m_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_sym | input | SYM_W (8) | Input symbol |
| m_valid | output | 1 | Count valid |
| m_ready | input | 1 | Consumer takes the count |
| m_count | output | 3 | Number of mismatching positions, 0 to 4 |
| ref_we | input | 1 | Reference write strobe |
| ref_sel | input | 2 | Tap index of the reference to write |
| ref_data | input | SYM_W (8) | Reference value to write |

## Verification
The assertions assume that reset is held from time zero until at least one clock edge. The three-cycle latency and bubble properties assume no reset falls inside their window. The hold property assumes the consumer alone decides when a stalled count leaves. The stimulus asserts reset before the first edge and applies reset only as whole cycles. Reference writes go in idle cycles, except one deliberate write in the same cycle as an accepted sample. Symbol values are kept to a small range so that matches and mismatches both occur often.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int TAPS    = 4;
  localparam int CNT_W   = $clog2(TAPS + 1);
  localparam int SEL_W   = $clog2(TAPS);
  localparam int LATENCY = TAPS - 1;
endpackage

// File: rtl/corr_ref_bank.sv
module corr_ref_bank
  import corr_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [SEL_W-1:0]            sel,
  input  logic [SYM_W-1:0]            wdata,
  output logic [TAPS-1:0][SYM_W-1:0]  refs
);
  for (genvar gi = 0; gi < TAPS; gi++) begin : g_ref
    always_ff @(posedge clk) begin
      if (rst)
        refs[gi] <= '0;
      else if (we && (sel == SEL_W'(gi)))
        refs[gi] <= wdata;
    end
  end
endmodule

// File: rtl/corr_tap_chain.sv
module corr_tap_chain
  import corr_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift,
  input  logic [SYM_W-1:0]            sym_in,
  input  logic [TAPS-1:0][SYM_W-1:0]  refs,
  output logic [TAPS-1:0]             miss
);
  localparam int HIST = TAPS - 1;

  logic [HIST-1:0][SYM_W-1:0] hist;
  logic [TAPS-1:0][SYM_W-1:0] tapv;

  // history moves one place per accepted sample
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (shift) begin
      hist[0] <= sym_in;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    tapv[0] = sym_in;
    for (int i = 1; i < TAPS; i++) tapv[i] = hist[i-1];
  end

  for (genvar gi = 0; gi < TAPS; gi++) begin : g_cmp
    assign miss[gi] = (tapv[gi] != refs[gi]);
  end
endmodule

// File: rtl/corr_adder_pipe.sv
module corr_adder_pipe
  import corr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [TAPS-1:0]  miss,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_count
);
  // stage 1: comparators plus one adder; taps 0 and 1 ride along
  logic       v1;
  logic [1:0] sum1;
  logic [1:0] keep1;
  // stage 2: one adder; tap 0 rides along
  logic       v2;
  logic [1:0] sum2;
  logic       keep2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      sum1      <= '0;
      keep1     <= '0;
      sum2      <= '0;
      keep2     <= 1'b0;
      out_count <= '0;
    end else if (adv) begin
      v1        <= in_valid;
      sum1      <= {1'b0, miss[3]} + {1'b0, miss[2]};
      keep1     <= miss[1:0];
      v2        <= v1;
      sum2      <= sum1 + {1'b0, keep1[1]};
      keep2     <= keep1[0];
      out_valid <= v2;
      out_count <= {1'b0, sum2} + {{(CNT_W-1){1'b0}}, keep2};
    end
  end
endmodule

// File: rtl/corr_mismatch_top.sv
module corr_mismatch_top
  import corr_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SYM_W-1:0] s_sym,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [CNT_W-1:0] m_count,
  input  logic             ref_we,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic [SYM_W-1:0] ref_data
);
  logic                       adv;
  logic                       accept;
  logic [TAPS-1:0][SYM_W-1:0] refs;
  logic [TAPS-1:0]            miss;

  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;
  assign accept  = s_valid && adv;

  corr_ref_bank #(.SYM_W(SYM_W)) u_refs (
    .clk   (clk),
    .rst   (rst),
    .we    (ref_we),
    .sel   (ref_sel),
    .wdata (ref_data),
    .refs  (refs)
  );

  corr_tap_chain #(.SYM_W(SYM_W)) u_taps (
    .clk    (clk),
    .rst    (rst),
    .shift  (accept),
    .sym_in (s_sym),
    .refs   (refs),
    .miss   (miss)
  );

  corr_adder_pipe u_sum (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .in_valid  (accept),
    .miss      (miss),
    .out_valid (m_valid),
    .out_count (m_count)
  );
endmodule

// File: rtl/corr_mismatch_chk.sv
module corr_mismatch_chk
  import corr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [CNT_W-1:0] m_count
);
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_count <= CNT_W'(TAPS)));

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_count)));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !m_valid);

  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) ##1 s_ready ##1 s_ready |=> m_valid);

  a_r5_bubble: assert property (@(posedge clk) disable iff (rst)
    (!s_valid && s_ready) ##1 s_ready ##1 s_ready |=> !m_valid);
endmodule

bind corr_mismatch_top corr_mismatch_chk u_chk (.*);

// File: tb/tb_corr_mismatch_top.sv
module tb_corr_mismatch_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_sym = '0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [2:0] m_count;
  logic       ref_we = 1'b0;
  logic [1:0] ref_sel = '0;
  logic [7:0] ref_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int mref[4];
  int mhist[3];
  bit pv[3];
  int pc[3];

  // table: {sym, expected count}, refs 1,2,3,4, history zero, no stalls
  localparam int NT = 14;
  localparam logic [10:0] TAB [NT] = '{
    {8'd1, 3'd3}, {8'd2, 3'd4}, {8'd3, 3'd3}, {8'd4, 3'd4},
    {8'd3, 3'd3}, {8'd2, 3'd4}, {8'd1, 3'd0}, {8'd1, 3'd3},
    {8'd9, 3'd4}, {8'd4, 3'd4}, {8'd3, 3'd4}, {8'd2, 3'd4},
    {8'd5, 3'd1}, {8'd1, 3'd3}
  };

  always #2.5 clk = ~clk;

  corr_mismatch_top dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_sym(s_sym),
    .m_valid(m_valid), .m_ready(m_ready), .m_count(m_count),
    .ref_we(ref_we), .ref_sel(ref_sel), .ref_data(ref_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit sv, input int sym, input bit mr, input bit we,
                      input int sel, input int wd, input bit rs,
                      input bit tab, input int texp, input string tag);
    bit adv, acc;
    int e;
    s_valid = sv; s_sym = sym[7:0]; m_ready = mr; ref_we = we;
    ref_sel = sel[1:0]; ref_data = wd[7:0]; rst = rs;
    #1;
    adv = !m_valid || mr;
    if (!rs) chk(s_ready == adv, {tag, " R6 s_ready"}, int'(s_ready), int'(adv));
    acc = sv && adv && !rs;
    e = int'(sym[7:0] != mref[0]) + int'(mhist[0] != mref[1])
      + int'(mhist[1] != mref[2]) + int'(mhist[2] != mref[3]);
    if (tab) e = texp;
    @(posedge clk);
    if (rs) begin
      foreach (pv[i]) begin pv[i] = 0; pc[i] = 0; end
      foreach (mhist[i]) mhist[i] = 0;
      foreach (mref[i]) mref[i] = 0;
    end else begin
      if (adv) begin
        pv[2] = pv[1]; pc[2] = pc[1];
        pv[1] = pv[0]; pc[1] = pc[0];
        pv[0] = acc;   pc[0] = e;
      end
      if (acc) begin
        mhist[2] = mhist[1]; mhist[1] = mhist[0]; mhist[0] = sym[7:0];
      end
      if (we) mref[sel] = wd[7:0];
    end
    #1;
    chk(m_valid == pv[2], {tag, " m_valid"}, int'(m_valid), int'(pv[2]));
    if (pv[2] && m_valid)
      chk(int'(m_count) == pc[2], {tag, " m_count"}, int'(m_count), pc[2]);
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int seed;
    foreach (mref[i]) mref[i] = 0;
    foreach (mhist[i]) mhist[i] = 0;
    foreach (pv[i]) begin pv[i] = 0; pc[i] = 0; end

    // R8: reset state
    repeat (3) tick(0, 0, 1, 0, 0, 0, 1, 0, 0, "R8 reset");
    tick(0, 0, 1, 0, 0, 0, 0, 0, 0, "R8 after reset");
    chk(s_ready == 1'b1, "R8 s_ready after reset", int'(s_ready), 1);

    // R7: load refs 1..4 while idle
    for (int k = 0; k < 4; k++) tick(0, 0, 1, 1, k, k + 1, 0, 0, 0, "R7 load");

    // R1 R2 R4: vector table, back to back
    for (int k = 0; k < NT; k++)
      tick(1, int'(TAB[k][10:3]), 1, 0, 0, 0, 0, 1, int'(TAB[k][2:0]), "R1 R2 R4 table");
    repeat (3) tick(0, 0, 1, 0, 0, 0, 0, 0, 0, "R5 flush");

    // R3 R5: bubbles between samples
    for (int k = 0; k < 12; k++)
      tick(k % 3 != 1, k % 5, 1, 0, 0, 0, 0, 0, 0, "R3 R5 bubbles");

    // R6: back-pressure with samples offered
    for (int k = 0; k < 6; k++) tick(1, k % 4 + 1, 0, 0, 0, 0, 0, 0, 0, "R6 stall");
    for (int k = 0; k < 4; k++) tick(1, 4 - k, 1, 0, 0, 0, 0, 0, 0, "R6 release");
    tick(1, 2, 0, 0, 0, 0, 0, 0, 0, "R6 stall2");
    tick(0, 2, 0, 0, 0, 0, 0, 0, 0, "R6 stall2");
    repeat (4) tick(0, 0, 1, 0, 0, 0, 0, 0, 0, "R6 drain");

    // R7: write in the same cycle as an accepted sample, then after
    tick(1, 7, 1, 1, 0, 7, 0, 0, 0, "R7 same cycle");
    tick(1, 7, 1, 0, 0, 0, 0, 0, 0, "R7 next sample");
    tick(0, 0, 1, 1, 3, 9, 0, 0, 0, "R7 idle write");
    tick(1, 7, 1, 0, 0, 0, 0, 0, 0, "R7 uses tap3");
    repeat (3) tick(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 flush");

    // R1 R6: mixed stream with occasional stalls and idle writes
    seed = 17;
    for (int k = 0; k < 300; k++) begin
      bit sv, mr, we;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      sv = seed[4:3] != 2'b00;
      mr = seed[7:5] != 3'b000;
      we = !sv && seed[9];
      tick(sv, seed[17:16], mr, we, seed[12:11], seed[14:13], 0, 0, 0, "R1 mixed");
    end

    // R8: reset mid-stream clears history and refs
    tick(1, 3, 1, 0, 0, 0, 0, 0, 0, "R8 pre");
    tick(1, 3, 1, 0, 0, 0, 1, 0, 0, "R8 mid reset");
    tick(1, 0, 1, 0, 0, 0, 0, 0, 0, "R8 zero sample");
    repeat (3) tick(0, 0, 1, 0, 0, 0, 0, 0, 0, "R8 flush");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule